// File: doc/BRIEF.md
# Free-Running Timer with Dual Alarms

This block is a 40-bit binary up-counter driven by a fast internal clock. The count is made of two fields: an 8-bit sub-interval field that advances once per clock while the timer runs, and a 32-bit interval field that steps by one whenever the sub-interval field wraps to zero. Software starts and stops the count, and it can preset the count while the timer is halted.

Two alarms are built on the count. The long alarm compares the low 20 bits of the interval field with a programmed value. It sets a sticky flag when the interval field reaches that value. The short alarm is a 32-bit counter that is loaded from a reload register when it is switched on. It then advances with every sub-interval step and raises a sticky flag each time it wraps past all-ones. On that wrap it reloads itself, so the alarm repeats at a fixed period of 2^32 minus the reload value. A reload of zero gives the longest period. Each flag can drive a single interrupt line through its own enable.

Top module: `tmr_dual_alarm`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The register map is: 0 control (bit0 run, bit1 long-alarm enable, bit2 short-alarm enable, bit3 short-alarm interrupt enable), 1 flags (bit0 long, bit1 short), 2 sub-interval count, 3 interval count, 4 long compare value, 5 short reload value. Reads go through `rd_addr` to `rd_data` with no delay.
- R2: While run is 1, the sub-interval count rises by one on every clock edge. When it passes from 0xFF to 0x00, the interval count rises by one on the same edge. While run is 0, both fields hold.
- R3: Writes to addresses 2 and 3 take effect only while run is 0 and are ignored while the timer runs. Reading any register leaves the count unchanged.
- R4: The long flag (flags bit0) is set on the edge where the interval count steps to a value whose bits [19:0] equal the compare value. This happens whether or not the long-alarm enable is set.
- R5: A write to the compare register (address 4) is ignored while the long-alarm enable is 1.
- R6: Writing control with bit2 set while the short alarm is off loads the short counter from the reload value. While enabled and running, the counter advances once per sub-interval step. On a step from 0xFFFFFFFF it sets the short flag (flags bit1) and reloads on the same edge, so a reload value V gives a flag every 2^32−V steps.
- R7: A reload value of zero gives the longest short-alarm period, 2^32 steps: no short flag appears within the first 2^32−1 steps after enabling.
- R8: A write to the reload register (address 5) is ignored while the short-alarm enable is 1.
- R9: Flags are cleared by writing 1 to their bit at address 1. Writing 0 leaves them unchanged. A hardware set on the same edge as a clear wins.
- R10: `irq` is high exactly when the long flag is set with the long-alarm enable on, or when the short flag is set with the short-alarm interrupt enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr`, zero-extended |
| irq | output | 1 | Combined alarm interrupt |

## Verification
A register write is captured on the clock edge that samples `wr_en`. The new value can be read straight after that edge. While the timer runs, the count read after N further edges equals the start value plus N. Both flags and `irq` change on the same edge as the step that triggers them. The short alarm therefore flags exactly (2^32−V) edges after the edge that both enabled it and started it running. The scoreboard stamps every expected value with the cycle count at which it is due. The monitor samples each stamped item at the falling edge of that cycle, and it reports an item as failed if the item is still queued after its cycle has passed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned CTRL_W    = 4;
    localparam int unsigned NUM_FLAGS = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_SUB    = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_INTV   = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CMP    = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd5;

    localparam int unsigned FLAG_LONG  = 0;
    localparam int unsigned FLAG_SHORT = 1;

    // bit0 run, bit1 long enable, bit2 short enable, bit3 short irq enable
    typedef struct packed {
        logic short_ie;
        logic short_en;
        logic long_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/tmr_count.sv
// Two-field running count: sub field steps every enabled clock,
// high field steps when the sub field wraps.
module tmr_count #(
    parameter int unsigned SUB_W = 8,
    parameter int unsigned HI_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             sub_we_i,
    input  logic [SUB_W-1:0] sub_wdata_i,
    input  logic             hi_we_i,
    input  logic [HI_W-1:0]  hi_wdata_i,
    output logic [SUB_W-1:0] sub_o,
    output logic [HI_W-1:0]  hi_o,
    output logic             carry_o
);

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [SUB_W-1:0] sub;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        carry_o = run_i && (st_q.sub == '1);
        if (run_i) begin
            st_d.sub = st_q.sub + SUB_W'(1);
            if (carry_o) begin
                st_d.hi = st_q.hi + HI_W'(1);
            end
        end else begin
            if (sub_we_i) begin
                st_d.sub = sub_wdata_i;
            end
            if (hi_we_i) begin
                st_d.hi = hi_wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sub_o = st_q.sub;
    assign hi_o  = st_q.hi;

endmodule

// File: rtl/tmr_long_alarm.sv
// Match alarm on the low slice of the high count field.
module tmr_long_alarm #(
    parameter int unsigned CMP_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cmp_we_i,
    input  logic [CMP_W-1:0] cmp_wdata_i,
    input  logic             carry_i,
    input  logic [CMP_W-1:0] hi_low_i,
    output logic [CMP_W-1:0] cmp_o,
    output logic             hit_o
);

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
    } long_st_t;

    long_st_t st_d, st_q;
    logic [CMP_W-1:0] hi_low_next;

    always_comb begin
        st_d        = st_q;
        hi_low_next = hi_low_i + CMP_W'(1);
        // compare value is locked while the alarm is armed
        if (cmp_we_i && !en_i) begin
            st_d.cmp = cmp_wdata_i;
        end
        hit_o = carry_i && (hi_low_next == st_q.cmp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_o = st_q.cmp;

endmodule

// File: rtl/tmr_short_alarm.sv
// Auto-reload interval alarm: load on enable, count up, flag and reload on wrap.
module tmr_short_alarm #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             rld_we_i,
    input  logic [CNT_W-1:0] rld_wdata_i,
    output logic [CNT_W-1:0] reload_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
    } short_st_t;

    short_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = 1'b0;
        if (rld_we_i && !en_i) begin
            st_d.reload = rld_wdata_i;
        end
        if (start_i) begin
            st_d.cnt = st_q.reload;
        end else if (en_i && tick_i) begin
            if (st_q.cnt == '1) begin
                wrap_o   = 1'b1;
                st_d.cnt = st_q.reload;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_o = st_q.reload;

endmodule

// File: rtl/tmr_dual_alarm.sv
module tmr_dual_alarm
    import tmr_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SUB_W   = 8,
    parameter int unsigned HI_W    = 32,
    parameter int unsigned CMP_W   = 20,
    parameter int unsigned SHORT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);

    typedef struct packed {
        ctrl_t                ctrl;
        logic [NUM_FLAGS-1:0] flags;
    } top_st_t;

    top_st_t st_d, st_q;

    logic we_ctrl, we_flags, we_sub, we_hi, we_cmp, we_rld;
    logic ctrl_run, ctrl_long_en, ctrl_short_en, ctrl_short_ie;
    logic [NUM_FLAGS-1:0] flag_q, flag_set, flag_clr, irq_mask;
    logic short_start;

    logic [SUB_W-1:0]   sub_cnt;
    logic [HI_W-1:0]    hi_cnt;
    logic               hi_carry;
    logic               long_hit;
    logic [CMP_W-1:0]   cmp_val;
    logic [SHORT_W-1:0] reload_val;
    logic               short_wrap;

    assign ctrl_run      = st_q.ctrl.run;
    assign ctrl_long_en  = st_q.ctrl.long_en;
    assign ctrl_short_en = st_q.ctrl.short_en;
    assign ctrl_short_ie = st_q.ctrl.short_ie;
    assign flag_q        = st_q.flags;

    // write decode; count presets only while halted
    always_comb begin
        we_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
        we_flags = wr_en && (wr_addr == ADDR_FLAGS);
        we_sub   = wr_en && (wr_addr == ADDR_SUB) && !ctrl_run;
        we_hi    = wr_en && (wr_addr == ADDR_INTV) && !ctrl_run;
        we_cmp   = wr_en && (wr_addr == ADDR_CMP);
        we_rld   = wr_en && (wr_addr == ADDR_RELOAD);
        short_start = we_ctrl && wr_data[2] && !ctrl_short_en;
    end

    tmr_count #(
        .SUB_W (SUB_W),
        .HI_W  (HI_W)
    ) count_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (ctrl_run),
        .sub_we_i    (we_sub),
        .sub_wdata_i (wr_data[SUB_W-1:0]),
        .hi_we_i     (we_hi),
        .hi_wdata_i  (wr_data[HI_W-1:0]),
        .sub_o       (sub_cnt),
        .hi_o        (hi_cnt),
        .carry_o     (hi_carry)
    );

    tmr_long_alarm #(
        .CMP_W (CMP_W)
    ) long_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl_long_en),
        .cmp_we_i    (we_cmp),
        .cmp_wdata_i (wr_data[CMP_W-1:0]),
        .carry_i     (hi_carry),
        .hi_low_i    (hi_cnt[CMP_W-1:0]),
        .cmp_o       (cmp_val),
        .hit_o       (long_hit)
    );

    tmr_short_alarm #(
        .CNT_W (SHORT_W)
    ) short_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl_short_en),
        .start_i     (short_start),
        .tick_i      (ctrl_run),
        .rld_we_i    (we_rld),
        .rld_wdata_i (wr_data[SHORT_W-1:0]),
        .reload_o    (reload_val),
        .wrap_o      (short_wrap)
    );

    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_LONG]  = long_hit;
        flag_set[FLAG_SHORT] = short_wrap;
        flag_clr             = we_flags ? wr_data[NUM_FLAGS-1:0] : '0;
        irq_mask             = '0;
        irq_mask[FLAG_LONG]  = ctrl_long_en;
        irq_mask[FLAG_SHORT] = ctrl_short_ie;
    end

    // next state: control and flags (set beats clear)
    always_comb begin
        st_d = st_q;
        if (we_ctrl) begin
            st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        end
        st_d.flags = (st_q.flags & ~flag_clr) | flag_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = |(flag_q & irq_mask);

    always_comb begin
        case (rd_addr)
            ADDR_CTRL:   rd_data = DATA_W'(st_q.ctrl);
            ADDR_FLAGS:  rd_data = DATA_W'(flag_q);
            ADDR_SUB:    rd_data = DATA_W'(sub_cnt);
            ADDR_INTV:   rd_data = DATA_W'(hi_cnt);
            ADDR_CMP:    rd_data = DATA_W'(cmp_val);
            ADDR_RELOAD: rd_data = DATA_W'(reload_val);
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tmr_dual_alarm_chk.sv
module tmr_dual_alarm_chk
    import tmr_pkg::*;
#(
    parameter int unsigned SUB_W   = 8,
    parameter int unsigned HI_W    = 32,
    parameter int unsigned CMP_W   = 20,
    parameter int unsigned SHORT_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 run,
    input logic                 long_en,
    input logic                 short_en,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [NUM_FLAGS-1:0] wr_low,
    input logic [SUB_W-1:0]     sub,
    input logic [HI_W-1:0]      hi,
    input logic [CMP_W-1:0]     cmp,
    input logic [SHORT_W-1:0]   reload,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 irq
);

    a_r2_sub_step: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> sub == SUB_W'($past(sub) + SUB_W'(1)));

    a_r2_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sub == '1) |=> hi == HI_W'($past(hi) + HI_W'(1)));

    a_r2_sub_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(wr_en && wr_addr == ADDR_SUB)) |=> $stable(sub));

    a_r3_hi_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sub != '1) |=> $stable(hi));

    a_r4_long_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLAG_LONG]) |-> hi[CMP_W-1:0] == cmp);

    a_r5_cmp_locked: assert property (@(posedge clk) disable iff (!rst_n)
        long_en |=> $stable(cmp));

    a_r8_reload_locked: assert property (@(posedge clk) disable iff (!rst_n)
        short_en |=> $stable(reload));

    a_r9_short_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_SHORT] && !(wr_en && wr_addr == ADDR_FLAGS && wr_low[FLAG_SHORT]))
        |=> flags[FLAG_SHORT]);

    a_r9_long_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_LONG] && !(wr_en && wr_addr == ADDR_FLAGS && wr_low[FLAG_LONG]))
        |=> flags[FLAG_LONG]);

    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flags != '0);

endmodule

bind tmr_dual_alarm tmr_dual_alarm_chk #(
    .SUB_W   (SUB_W),
    .HI_W    (HI_W),
    .CMP_W   (CMP_W),
    .SHORT_W (SHORT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_run),
    .long_en  (ctrl_long_en),
    .short_en (ctrl_short_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_low   (wr_data[1:0]),
    .sub      (sub_cnt),
    .hi       (hi_cnt),
    .cmp      (cmp_val),
    .reload   (reload_val),
    .flags    (flag_q),
    .irq      (irq)
);

// File: tb/tmr_dual_alarm_tb_top.sv
`timescale 1ns/100ps
module tmr_dual_alarm_tb_top;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    always #4 clk = ~clk;   // 125 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int K;

    typedef struct {
        int          stamp;
        bit          is_irq;
        logic [2:0]  addr;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];

    tmr_dual_alarm dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq     (irq)
    );

    task automatic push(input int st, input bit is_irq, input logic [2:0] a,
                        input logic [31:0] e, input string r);
        item_t it;
        it.stamp = st; it.is_irq = is_irq; it.addr = a; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // write captured on edge number e
    task automatic wr_at(input int e, input logic [2:0] a, input logic [31:0] d);
        while (cyc < e - 1) @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    // monitor: pops each item in its due cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].stamp <= cyc) begin
                item_t it;
                logic [31:0] got;
                it = sb.pop_front();
                checks++;
                if (it.stamp < cyc) begin
                    errors++;
                    $display("FAIL %s: sample due at cycle %0d missed, actual none expected %h",
                             it.req, it.stamp, it.exp);
                end else begin
                    rd_addr = it.addr;
                    #0.1;
                    got = it.is_irq ? {31'b0, irq} : rd_data;
                    if (got !== it.exp) begin
                        errors++;
                        $display("FAIL %s: cycle %0d %s actual %h expected %h", it.req, cyc,
                                 it.is_irq ? "irq" : "reg", got, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        K = cyc;
        // R1 reset state
        for (int a = 0; a < 6; a++) push(K + 1, 1'b0, 3'(a), 32'h0, "R1");
        push(K + 1, 1'b1, 3'd0, 32'h0, "R1 irq");
        drain();

        // R3 preset while halted, R2 counting and carry
        wr(ADDR_SUB, 32'hFD);
        wr(ADDR_INTV, 32'h5);
        push(cyc, 1'b0, ADDR_SUB, 32'hFD, "R3 preset sub");
        push(cyc, 1'b0, ADDR_INTV, 32'h5, "R3 preset intv");
        wr(ADDR_CTRL, 32'h1);
        K = cyc;
        push(K + 1, 1'b0, ADDR_SUB, 32'hFE, "R2 step");
        push(K + 2, 1'b0, ADDR_SUB, 32'hFF, "R2 step");
        push(K + 2, 1'b0, ADDR_INTV, 32'h5, "R2 no carry yet");
        push(K + 3, 1'b0, ADDR_SUB, 32'h00, "R2 wrap");
        push(K + 3, 1'b0, ADDR_INTV, 32'h6, "R2 carry");
        push(K + 4, 1'b0, ADDR_SUB, 32'h01, "R2 step after wrap");
        wr_at(K + 6, ADDR_SUB, 32'h40);
        push(K + 6, 1'b0, ADDR_SUB, 32'h03, "R3 sub write ignored while running");
        wr_at(K + 8, ADDR_INTV, 32'h99);
        push(K + 8, 1'b0, ADDR_INTV, 32'h6, "R3 intv write ignored while running");
        push(K + 8, 1'b0, ADDR_SUB, 32'h05, "R3 reads leave count intact");
        wr_at(K + 10, ADDR_CTRL, 32'h0);
        push(K + 13, 1'b0, ADDR_SUB, 32'h07, "R2 hold when halted");
        drain();

        // R5 compare lock, R4 long match, R10, R9
        wr(ADDR_SUB, 32'hFE);
        wr(ADDR_INTV, 32'hABC0_0006);
        wr(ADDR_CMP, 32'h7);
        wr(ADDR_CTRL, 32'h2);
        wr(ADDR_CMP, 32'h12345);
        push(cyc, 1'b0, ADDR_CMP, 32'h7, "R5 compare locked");
        wr(ADDR_CTRL, 32'h3);
        K = cyc;
        push(K + 1, 1'b0, ADDR_FLAGS, 32'h0, "R4 no match yet");
        push(K + 1, 1'b1, 3'd0, 32'h0, "R10 irq low");
        push(K + 2, 1'b0, ADDR_FLAGS, 32'h1, "R4 long flag on match");
        push(K + 2, 1'b0, ADDR_INTV, 32'hABC0_0007, "R4 interval at match");
        push(K + 2, 1'b1, 3'd0, 32'h1, "R10 irq from long");
        drain();
        wr(ADDR_CTRL, 32'h1);
        push(cyc, 1'b1, 3'd0, 32'h0, "R10 long irq masked");
        push(cyc, 1'b0, ADDR_FLAGS, 32'h1, "R9 flag stays");
        wr(ADDR_CTRL, 32'h0);
        wr(ADDR_FLAGS, 32'h0);
        push(cyc, 1'b0, ADDR_FLAGS, 32'h1, "R9 write zero no effect");
        wr(ADDR_FLAGS, 32'h1);
        push(cyc, 1'b0, ADDR_FLAGS, 32'h0, "R9 write one clears");
        drain();

        // R8 reload lock, R6 periodic alarm, R9 set beats clear
        wr(ADDR_RELOAD, 32'hFFFF_FFFD);
        wr(ADDR_CTRL, 32'hC);
        wr(ADDR_RELOAD, 32'h5);
        push(cyc, 1'b0, ADDR_RELOAD, 32'hFFFF_FFFD, "R8 reload locked");
        wr(ADDR_CTRL, 32'hD);
        K = cyc;
        push(K + 2, 1'b0, ADDR_FLAGS, 32'h0, "R6 before wrap");
        push(K + 3, 1'b0, ADDR_FLAGS, 32'h2, "R6 short flag on wrap");
        push(K + 3, 1'b1, 3'd0, 32'h1, "R10 irq from short");
        push(K + 4, 1'b0, ADDR_FLAGS, 32'h2, "R9 short sticky");
        wr_at(K + 6, ADDR_FLAGS, 32'h2);
        push(K + 6, 1'b0, ADDR_FLAGS, 32'h2, "R9 set wins over clear");
        wr_at(K + 8, ADDR_FLAGS, 32'h2);
        push(K + 8, 1'b0, ADDR_FLAGS, 32'h0, "R9 short cleared");
        push(K + 8, 1'b1, 3'd0, 32'h0, "R10 irq drops");
        push(K + 9, 1'b0, ADDR_FLAGS, 32'h2, "R6 period of three");
        drain();
        wr(ADDR_CTRL, 32'h5);
        push(cyc, 1'b1, 3'd0, 32'h0, "R10 short irq masked");
        wr(ADDR_CTRL, 32'h0);
        drain();

        // R7 zero reload: longest period
        wr(ADDR_FLAGS, 32'h3);
        wr(ADDR_RELOAD, 32'h0);
        wr(ADDR_CTRL, 32'hC);
        wr(ADDR_CTRL, 32'hD);
        K = cyc;
        push(K + 1500, 1'b0, ADDR_FLAGS, 32'h0, "R7 no early alarm");
        drain();

        // R6 re-enable loads new reload value
        wr(ADDR_CTRL, 32'hC);
        wr(ADDR_CTRL, 32'h0);
        wr(ADDR_RELOAD, 32'hFFFF_FFFE);
        push(cyc, 1'b0, ADDR_RELOAD, 32'hFFFF_FFFE, "R8 reload writable when off");
        wr(ADDR_CTRL, 32'hD);
        K = cyc;
        push(K + 1, 1'b0, ADDR_FLAGS, 32'h0, "R6 reload on enable");
        push(K + 2, 1'b0, ADDR_FLAGS, 32'h2, "R6 wrap after reload");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule